// File: doc/BRIEF.md
# Stepped Soft-Start Reference Controller

This block produces the digital reference code for a power-factor regulator's error amplifier during start-up. It climbs in equal stair steps from zero to the full-scale value, which stands for the 2.5 V reference, and then holds there. While it climbs, the feedback loop is closed by an internal proportional controller. Once the regulated output is reported at its rated value, a timed handover window runs. When the window ends, the loop is given to the external compensator.

Three inputs drive the block: a start enable (the supply has crossed its start level), a line-present flag (from an input-absence detector) and an at-rated flag. Three outputs come out of it: the reference code, a path select, and a done flag. When the line disappears, the ramp is cleared and the block waits. When the line returns, the ramp restarts from step zero. When the start enable drops, the block returns to zero at once.

The step count, the cycles per step, the handover length and the full-scale code are all parameters. The converter that turns the code into a voltage, the amplifier itself and the input-absence detector lie outside this block.

Top module: `ssref_top`

## Requirements
- R1: While reset is asserted, and directly after it, `ref_code` is 0, `use_ext` is 0 and `handover_done` is 0.
- R2: If `start_en` is low at a clock edge, then after that edge `ref_code` is 0, `use_ext` is 0 (the internal path) and `handover_done` is 0, whatever the other inputs are.
- R3: With `start_en` and `line_ok` both high, the ramp starts at step 0 on the first edge. It then advances one step every `STEP_CYCLES` clock cycles. Step k outputs the code floor(k*`FULL_CODE`/`N_STEPS`), so the code never falls while both inputs stay high.
- R4: After `N_STEPS` steps the code equals `FULL_CODE` exactly. It is held there and never exceeds it.
- R5: `use_ext` is 0 (internal proportional path) for the whole ramp. `use_ext` is 1 only while `ref_code` equals `FULL_CODE`.
- R6: After the ramp completes, `at_rated` must be high for `HAND_CYCLES` consecutive cycles. On the edge that ends that run, `use_ext` and `handover_done` rise together. Any low cycle of `at_rated` restarts the count.
- R7: `at_rated` has no effect on the ramp's timing or on the path select while the ramp is still climbing.
- R8: If `line_ok` is low at an edge while `start_en` is high, then after that edge `ref_code`, `use_ext` and `handover_done` are 0. They stay 0 while the line is absent. When the line returns, the ramp restarts from step 0.
- R9: Once the handover has completed, `use_ext` and `handover_done` stay 1 while `start_en` and `line_ok` stay high, whatever `at_rated` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Supply above start level; low forces idle |
| line_ok | input | 1 | Input power present; low clears and holds the ramp |
| at_rated | input | 1 | Regulated output has reached its rated value |
| ref_code | output | CODE_W | Stepped reference code |
| use_ext | output | 1 | 0 selects the internal proportional path, 1 the external compensator |
| handover_done | output | 1 | Handover to the external path has completed |

## Verification
The bench builds the block with 8 steps of 4 cycles, a 6-cycle handover window and a full-scale code of 1000. With these values every step value is an exact multiple of 125. The whole ramp and the handover fit in a few dozen cycles, so the bench can check each stair step, the exact edge on which control changes path, an interrupted handover count, line loss and return, and enable loss. The defaults (thousands of cycles per step, hundreds of thousands for the handover) use the same counter and comparison logic at wider widths.

// File: rtl/ssref_pkg.sv
package ssref_pkg;

    typedef enum logic [2:0] {
        SS_OFF  = 3'd0,   // start enable low
        SS_WAIT = 3'd1,   // line absent, ramp cleared
        SS_RAMP = 3'd2,   // climbing in steps, internal path
        SS_HOLD = 3'd3,   // at full scale, counting handover window
        SS_EXT  = 3'd4    // external compensator in control
    } ss_state_e;

endpackage

// File: rtl/ssref_ctrl.sv
module ssref_ctrl
    import ssref_pkg::*;
#(
    parameter int N_STEPS     = 32,
    parameter int STEP_CYCLES = 1563,
    parameter int HAND_CYCLES = 300000,
    localparam int IDX_W      = $clog2(N_STEPS + 1),
    localparam int TMR_MAX    = (STEP_CYCLES > HAND_CYCLES) ? STEP_CYCLES : HAND_CYCLES,
    localparam int TMR_W      = $clog2(TMR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_en,
    input  logic             line_ok,
    input  logic             at_rated,
    output logic [IDX_W-1:0] step_idx,
    output logic             ext_sel,
    output logic             done
);

    localparam logic [TMR_W-1:0] STEP_LAST = TMR_W'(STEP_CYCLES - 1);
    localparam logic [TMR_W-1:0] HAND_LAST = TMR_W'(HAND_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_STEPS);

    typedef struct packed {
        ss_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [TMR_W-1:0] tmr;
        logic             ext;
        logic             done;
    } ctrl_s;

    ctrl_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!start_en) begin
            s_d.state = SS_OFF;
            s_d.idx   = '0;
            s_d.tmr   = '0;
            s_d.ext   = 1'b0;
            s_d.done  = 1'b0;
        end else if (!line_ok) begin
            s_d.state = SS_WAIT;
            s_d.idx   = '0;
            s_d.tmr   = '0;
            s_d.ext   = 1'b0;
            s_d.done  = 1'b0;
        end else begin
            unique case (s_q.state)
                SS_OFF, SS_WAIT: begin
                    s_d.state = SS_RAMP;
                    s_d.idx   = '0;
                    s_d.tmr   = '0;
                end
                SS_RAMP: begin
                    if (s_q.tmr == STEP_LAST) begin
                        s_d.tmr = '0;
                        s_d.idx = s_q.idx + 1'b1;
                        if (s_q.idx + 1'b1 == IDX_LAST) begin
                            s_d.state = SS_HOLD;
                        end
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                SS_HOLD: begin
                    if (!at_rated) begin
                        s_d.tmr = '0;
                    end else if (s_q.tmr == HAND_LAST) begin
                        s_d.tmr   = '0;
                        s_d.state = SS_EXT;
                        s_d.ext   = 1'b1;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                SS_EXT: begin
                    s_d.ext  = 1'b1;
                    s_d.done = 1'b1;
                end
                default: begin
                    s_d.state = SS_OFF;
                    s_d.idx   = '0;
                    s_d.tmr   = '0;
                    s_d.ext   = 1'b0;
                    s_d.done  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SS_OFF, idx: '0, tmr: '0, ext: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign step_idx = s_q.idx;
    assign ext_sel  = s_q.ext;
    assign done     = s_q.done;

endmodule

// File: rtl/ssref_code_map.sv
module ssref_code_map #(
    parameter int N_STEPS   = 32,
    parameter int CODE_W    = 12,
    parameter int FULL_CODE = 1000,
    localparam int IDX_W    = $clog2(N_STEPS + 1),
    localparam int PROD_W   = CODE_W + IDX_W,
    localparam bit POW2     = ((N_STEPS & (N_STEPS - 1)) == 0),
    localparam int SHIFT    = $clog2(N_STEPS)
) (
    input  logic [IDX_W-1:0]  step_idx,
    output logic [CODE_W-1:0] code
);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    assign prod = PROD_W'(step_idx) * PROD_W'(FULL_CODE);

    generate
        if (POW2) begin : g_shift
            assign quot = prod >> SHIFT;
        end else begin : g_div
            assign quot = prod / PROD_W'(N_STEPS);
        end
    endgenerate

    assign code = quot[CODE_W-1:0];

endmodule

// File: rtl/ssref_top.sv
module ssref_top #(
    parameter int CODE_W      = 12,
    parameter int FULL_CODE   = 1000,
    parameter int N_STEPS     = 32,
    parameter int STEP_CYCLES = 1563,
    parameter int HAND_CYCLES = 300000,
    localparam int IDX_W      = $clog2(N_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic              line_ok,
    input  logic              at_rated,
    output logic [CODE_W-1:0] ref_code,
    output logic              use_ext,
    output logic              handover_done
);

    logic [IDX_W-1:0] step_idx;

    ssref_ctrl #(
        .N_STEPS    (N_STEPS),
        .STEP_CYCLES(STEP_CYCLES),
        .HAND_CYCLES(HAND_CYCLES)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_en(start_en),
        .line_ok (line_ok),
        .at_rated(at_rated),
        .step_idx(step_idx),
        .ext_sel (use_ext),
        .done    (handover_done)
    );

    ssref_code_map #(
        .N_STEPS  (N_STEPS),
        .CODE_W   (CODE_W),
        .FULL_CODE(FULL_CODE)
    ) i_map (
        .step_idx(step_idx),
        .code    (ref_code)
    );

endmodule

// File: rtl/ssref_chk.sv
module ssref_chk #(
    parameter int CODE_W    = 12,
    parameter int FULL_CODE = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_en,
    input logic              line_ok,
    input logic              at_rated,
    input logic [CODE_W-1:0] ref_code,
    input logic              use_ext,
    input logic              handover_done
);

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_en |=> (ref_code == '0 && !use_ext && !handover_done)); // R2

    AST_NO_DESCENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_en && line_ok) |-> ref_code >= $past(ref_code)); // R3

    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= CODE_W'(FULL_CODE)); // R4

    AST_EXT_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        use_ext |-> ref_code == CODE_W'(FULL_CODE)); // R5

    AST_EXT_NEEDS_RATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(use_ext) |-> ($past(at_rated) && handover_done)); // R6

    AST_LINE_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && !line_ok) |=> (ref_code == '0 && !use_ext && !handover_done)); // R8

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && start_en && line_ok) |=> (use_ext && handover_done)); // R9

endmodule

bind ssref_top ssref_chk #(
    .CODE_W   (CODE_W),
    .FULL_CODE(FULL_CODE)
) i_ssref_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_en     (start_en),
    .line_ok      (line_ok),
    .at_rated     (at_rated),
    .ref_code     (ref_code),
    .use_ext      (use_ext),
    .handover_done(handover_done)
);

// File: tb/test_ssref_top.sv
module test_ssref_top;

    localparam int CW   = 12;
    localparam int FULL = 1000;
    localparam int NS   = 8;
    localparam int SC   = 4;
    localparam int HC   = 6;
    localparam int STEP = FULL / NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_en = 1'b0;
    logic          line_ok = 1'b0;
    logic          at_rated = 1'b0;
    logic [CW-1:0] ref_code;
    logic          use_ext;
    logic          handover_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ssref_top #(
        .CODE_W(CW), .FULL_CODE(FULL), .N_STEPS(NS),
        .STEP_CYCLES(SC), .HAND_CYCLES(HC)
    ) i_ssref_top (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .line_ok(line_ok),
        .at_rated(at_rated), .ref_code(ref_code), .use_ext(use_ext),
        .handover_done(handover_done)
    );

    typedef struct packed {
        logic       en;
        logic       line;
        logic       rated;
        logic [7:0] edges;
        logic [11:0] exp_ref;
        logic       exp_ext;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 8'd1,  12'd0,    1'b0, 4'd3}, // R3 step 0
        '{1'b1, 1'b1, 1'b0, 8'd4,  12'd125,  1'b0, 4'd3}, // R3 step 1
        '{1'b1, 1'b1, 1'b0, 8'd8,  12'd375,  1'b0, 4'd3}, // R3 step 3
        '{1'b1, 1'b1, 1'b1, 8'd4,  12'd500,  1'b0, 4'd7}, // R7 rated ignored in ramp
        '{1'b1, 1'b1, 1'b1, 8'd15, 12'd875,  1'b0, 4'd5}, // R5 internal path in ramp
        '{1'b1, 1'b1, 1'b1, 8'd1,  12'd1000, 1'b0, 4'd4}, // R4 full scale reached
        '{1'b1, 1'b1, 1'b1, 8'd5,  12'd1000, 1'b0, 4'd6}, // R6 window not yet over
        '{1'b1, 1'b1, 1'b0, 8'd1,  12'd1000, 1'b0, 4'd6}, // R6 count restarted
        '{1'b1, 1'b1, 1'b1, 8'd5,  12'd1000, 1'b0, 4'd6}, // R6 one short
        '{1'b1, 1'b1, 1'b1, 8'd1,  12'd1000, 1'b1, 4'd6}, // R6 handover edge
        '{1'b1, 1'b1, 1'b0, 8'd3,  12'd1000, 1'b1, 4'd9}, // R9 sticky
        '{1'b1, 1'b0, 1'b0, 8'd1,  12'd0,    1'b0, 4'd8}, // R8 line lost
        '{1'b1, 1'b0, 1'b1, 8'd10, 12'd0,    1'b0, 4'd8}, // R8 held while absent
        '{1'b1, 1'b1, 1'b0, 8'd1,  12'd0,    1'b0, 4'd8}, // R8 restart at step 0
        '{1'b1, 1'b1, 1'b0, 8'd4,  12'd125,  1'b0, 4'd8}, // R8 ramp resumes
        '{1'b0, 1'b1, 1'b1, 8'd1,  12'd0,    1'b0, 4'd2}, // R2 enable lost
        '{1'b0, 1'b1, 1'b1, 8'd20, 12'd0,    1'b0, 4'd2}  // R2 stays idle
    };

    task automatic check(input int req, input logic [CW-1:0] er, input logic ee);
        n_chk++;
        if (ref_code !== er || use_ext !== ee || handover_done !== ee) begin
            n_bad++;
            $display("FAIL R%0d: ref=%0d ext=%0b done=%0b, expected ref=%0d ext=done=%0b",
                     req, ref_code, use_ext, handover_done, er, ee);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, '0, 1'b0);                      // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1, '0, 1'b0);                      // R1 after release, inputs low

        for (int v = 0; v < NV; v++) begin
            start_en = TBL[v].en;
            line_ok  = TBL[v].line;
            at_rated = TBL[v].rated;
            repeat (int'(TBL[v].edges)) @(posedge clk);
            @(negedge clk);
            check(int'(TBL[v].req), TBL[v].exp_ref, TBL[v].exp_ext);
        end

        // Directed: full ramp with at_rated high from the start (R3, R4, R6)
        start_en = 1'b1; line_ok = 1'b1; at_rated = 1'b1;
        @(posedge clk); @(negedge clk);
        check(3, '0, 1'b0);
        for (int k = 1; k <= NS; k++) begin
            repeat (SC) @(posedge clk);
            @(negedge clk);
            check(3, CW'(k * STEP), 1'b0);       // R3 each stair, R4 at last
        end
        repeat (HC - 1) @(posedge clk);
        @(negedge clk);
        check(6, CW'(FULL), 1'b0);               // R6 one edge before handover
        @(posedge clk); @(negedge clk);
        check(6, CW'(FULL), 1'b1);               // R6 handover edge

        // Directed: asynchronous reset mid-operation (R1)
        rst_n = 1'b0;
        #1;
        check(1, '0, 1'b0);
        @(negedge clk);
        start_en = 1'b0; line_ok = 1'b0; at_rated = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(1, '0, 1'b0);

        finish_run();
    end

endmodule